// File: doc/BRIEF.md
# Dead-Block Correlating Prefetch Predictor

This block sits beside a direct-mapped L1 data cache and watches its access stream. For every cache line it keeps a running signature: a rotated XOR fold of hashed load/store instruction addresses that touched the line since it was last refilled. When a miss replaces a line, the block learns that the old line's final signature, combined with the old block address, was followed by a miss to the new block. It stores that pair in a set-associative correlation table with a small confidence counter.

On every later access the block forms the line's updated signature and looks it up. When a learned entry with enough confidence matches, the line is taken to be dead: the block asks for a prefetch of the block predicted to replace it. If an access shows that a stored signature did not end the line's life, that entry's confidence is lowered. The cache and the queueing of prefetches lie outside this block.

Top module: `dbcp_predictor`

## Requirements
- R1: After reset every history entry and every correlation entry is empty, all confidences are 0, and `pfValid` is 0.
- R2: The instruction hash is `h(pc) = pc[SIGW-1:0] XOR (pc[PCW-1:PCW-SIGW] << 3)`, truncated to SIGW bits.
- R3: A miss, or a hit on a line with no history, sets that line's signature to `h(pc)`, marks it valid and records its tag `blk[BLKW-1:IDXB]`; the line index is `blk[IDXB-1:0]`.
- R4: A hit on a line with history sets its signature to the old signature rotated left by one bit, XOR `h(pc)`.
- R5: A lookup key is `signature XOR blk[SIGW-1:0]`; its set is the key's low `log2(SETS)` bits and the whole key is the stored tag.
- R6: A miss on a line with history trains the key of the old signature and old block `{tag, index}`: on a match with the same predicted block the confidence rises by one, stopping at 3; on a match with another prediction the prediction is replaced and confidence becomes 1; without a match a new entry is installed with confidence 1.
- R7: A hit on a line with history lowers by one (not below 0) the confidence of the entry keyed by the line's old signature and block.
- R8: One cycle after an access whose updated key matches an entry with confidence 2 or more, `pfValid` is 1 for one cycle and `pfBlk` gives the entry's predicted block; the lookup sees the table as it was before that same access updated it.
- R9: An install replaces the way of the set with the lowest confidence (an empty way counts as 0), the lowest way index winning ties.
- R10: While `accValid` is 0 no history, table or output state changes and `pfValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accPc | input | PCW | Instruction address of the load/store |
| accBlk | input | BLKW | Block address accessed |
| accMiss | input | 1 | The access missed and refills its line |
| pfValid | output | 1 | Prefetch request valid |
| pfBlk | output | BLKW | Block address to prefetch |

## Verification
Every access is registered in one cycle: history and table updates made at the access edge are seen by the very next access, and a prefetch caused by an access appears on `pfValid`/`pfBlk` right after that same edge and lasts one cycle. The bench drives each access on a falling edge, lets one rising edge pass, and compares the outputs on the next falling edge against a model built from R2 to R9, which it then advances. Directed rounds teach one signature to confidence 3 and wear it back down, structured sweeps overflow the four-way sets so replacement order matters, and a long pseudo-random stream mixes hits and misses; idle cycles with toggling inputs sit in between.

// File: rtl/dbcp_pkg.sv
package dbcp_pkg;
  // Control-to-datapath strobes for one access
  typedef struct packed {
    logic histWr;  // write the line's history entry
    logic seed;    // restart signature from the hash alone
    logic train;   // train old signature toward the new block
    logic dec;     // weaken old signature, line survived
    logic fire;    // capture a prefetch prediction
  } dbcpStrobe_t;

  localparam int CONFW  = 2;
  localparam int PF_MIN = 2;
endpackage

// File: rtl/dbcp_dp.sv
module dbcp_dp
  import dbcp_pkg::*;
#(
  parameter int LINES = 1024,
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int BLKW  = 16,
  parameter int PCW   = 16,
  parameter int SIGW  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accValid,
  input  logic [PCW-1:0]   accPc,
  input  logic [BLKW-1:0]  accBlk,
  input  dbcpStrobe_t      st,
  output logic             histValid,
  output logic             newHit,
  output logic [CONFW-1:0] newConf,
  output logic [BLKW-1:0]  pfBlk
);
  localparam int IDXB = $clog2(LINES);
  localparam int TAGW = BLKW - IDXB;
  localparam int SETB = $clog2(SETS);
  localparam int WB   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [CONFW-1:0] CMAX = '1;

  logic [LINES-1:0] histV;
  logic [TAGW-1:0]  histTag [LINES];
  logic [SIGW-1:0]  histSig [LINES];
  logic             corV    [SETS][WAYS];
  logic [SIGW-1:0]  corKey  [SETS][WAYS];
  logic [BLKW-1:0]  corPred [SETS][WAYS];
  logic [CONFW-1:0] corConf [SETS][WAYS];

  function automatic logic [SIGW-1:0] hashPc(input logic [PCW-1:0] pc);
    logic [SIGW-1:0] hi;
    hi = pc[PCW-1 -: SIGW];
    return pc[SIGW-1:0] ^ (hi << 3);
  endfunction

  logic [IDXB-1:0] idx;
  logic [TAGW-1:0] tg;
  logic [SIGW-1:0] hPc, oldSig, newSig, keyOld, keyNew;
  logic [BLKW-1:0] oldBlk, newPred;
  logic [SETB-1:0] setOld, setNew;
  logic            oldHit, predSame;
  logic [WB-1:0]   oldWay, victim;
  logic [CONFW-1:0] oldConf, bestConf;

  always_comb begin
    idx     = accBlk[IDXB-1:0];
    tg      = accBlk[BLKW-1:IDXB];
    hPc     = hashPc(accPc);
    oldSig  = histSig[idx];
    newSig  = st.seed ? hPc : ({oldSig[SIGW-2:0], oldSig[SIGW-1]} ^ hPc);
    oldBlk  = {histTag[idx], idx};
    keyOld  = oldSig ^ oldBlk[SIGW-1:0];
    keyNew  = newSig ^ accBlk[SIGW-1:0];
    setOld  = keyOld[SETB-1:0];
    setNew  = keyNew[SETB-1:0];
    histValid = histV[idx];
    oldHit  = 1'b0; oldWay = '0;
    newHit  = 1'b0; newConf = '0; newPred = '0;
    victim  = '0;   bestConf = CMAX;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (corV[setOld][w] && corKey[setOld][w] == keyOld) begin
        oldHit = 1'b1; oldWay = WB'(w);
      end
      if (corV[setNew][w] && corKey[setNew][w] == keyNew) begin
        newHit = 1'b1; newConf = corConf[setNew][w]; newPred = corPred[setNew][w];
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (w == 0 || corConf[setOld][w] < bestConf) begin
        bestConf = corConf[setOld][w]; victim = WB'(w);
      end
    end
    oldConf  = corConf[setOld][oldWay];
    predSame = corPred[setOld][oldWay] == accBlk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      histV <= '0;
      pfBlk <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          corV[s][w]    <= 1'b0;
          corConf[s][w] <= '0;
        end
    end else begin
      if (st.histWr) histV[idx] <= 1'b1;
      if (st.train) begin
        if (oldHit)
          corConf[setOld][oldWay] <= predSame ? ((oldConf == CMAX) ? CMAX : oldConf + 1'b1)
                                              : CONFW'(1);
        else begin
          corV[setOld][victim]    <= 1'b1;
          corConf[setOld][victim] <= CONFW'(1);
        end
      end else if (st.dec && oldHit) begin
        corConf[setOld][oldWay] <= (oldConf == '0) ? '0 : oldConf - 1'b1;
      end
      if (st.fire) pfBlk <= newPred;
    end
  end

  always_ff @(posedge clk) begin
    if (st.histWr) begin
      histTag[idx] <= tg;
      histSig[idx] <= newSig;
    end
    if (st.train) begin
      if (oldHit) begin
        if (!predSame) corPred[setOld][oldWay] <= accBlk;
      end else begin
        corKey[setOld][victim]  <= keyOld;
        corPred[setOld][victim] <= accBlk;
      end
    end
  end

  // R3
  seed_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && st.seed) |=> histSig[$past(idx)] == hashPc($past(accPc)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |=> $stable(histV));

  // R8
  pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st.fire |=> $stable(pfBlk));

  for (genvar gs = 0; gs < SETS; gs++) begin : g_set
    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
      // R7
      conf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, corConf[gs][gw]} == {1'b0, $past(corConf[gs][gw])}) ||
        ({1'b0, corConf[gs][gw]} == {1'b0, $past(corConf[gs][gw])} + 1'b1) ||
        ({1'b0, corConf[gs][gw]} + 1'b1 == {1'b0, $past(corConf[gs][gw])}) ||
        (corConf[gs][gw] == CONFW'(1)));
    end
  end
endmodule

// File: rtl/dbcp_ctrl.sv
module dbcp_ctrl
  import dbcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accValid,
  input  logic             accMiss,
  input  logic             histValid,
  input  logic             newHit,
  input  logic [CONFW-1:0] newConf,
  output dbcpStrobe_t      st,
  output logic             pfValid
);
  always_comb begin
    st.histWr = accValid;
    st.seed   = accMiss || !histValid;
    st.train  = accValid && accMiss && histValid;
    st.dec    = accValid && !accMiss && histValid;
    st.fire   = accValid && newHit && (newConf >= CONFW'(PF_MIN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pfValid <= 1'b0;
    else        pfValid <= st.fire;
  end

  // R8
  pf_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid |-> $past(accValid));
endmodule

// File: rtl/dbcp_predictor.sv
module dbcp_predictor
  import dbcp_pkg::*;
#(
  parameter int LINES = 1024,
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int BLKW  = 16,
  parameter int PCW   = 16,
  parameter int SIGW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accValid,
  input  logic [PCW-1:0]  accPc,
  input  logic [BLKW-1:0] accBlk,
  input  logic            accMiss,
  output logic            pfValid,
  output logic [BLKW-1:0] pfBlk
);
  dbcpStrobe_t      st;
  logic             histValid, newHit;
  logic [CONFW-1:0] newConf;

  dbcp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accMiss(accMiss),
    .histValid(histValid), .newHit(newHit), .newConf(newConf),
    .st(st), .pfValid(pfValid)
  );

  dbcp_dp #(.LINES(LINES), .SETS(SETS), .WAYS(WAYS), .BLKW(BLKW),
            .PCW(PCW), .SIGW(SIGW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accPc(accPc),
    .accBlk(accBlk), .st(st), .histValid(histValid), .newHit(newHit),
    .newConf(newConf), .pfBlk(pfBlk)
  );
endmodule

// File: tb/sim_dbcp_predictor.sv
module sim_dbcp_predictor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic accValid = 1'b0;
  logic [15:0] accPc = '0;
  logic [15:0] accBlk = '0;
  logic accMiss = 1'b0;
  logic pfValid;
  logic [15:0] pfBlk;

  always #4 clk = ~clk;

  dbcp_predictor #(.LINES(16), .SETS(4), .WAYS(4), .BLKW(16), .PCW(16), .SIGW(12)) u0 (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accPc(accPc),
    .accBlk(accBlk), .accMiss(accMiss), .pfValid(pfValid), .pfBlk(pfBlk)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;

  // bench-side model state
  bit        hv [16];
  int        ht [16];
  int        hs [16];
  bit        cv [4][4];
  int        ck [4][4];
  int        cp [4][4];
  int        cc [4][4];
  bit        lastV;
  logic [15:0] lastB;

  function automatic int hsh(int pc);
    return ((pc & 12'hFFF) ^ ((((pc >> 4) & 12'hFFF) << 3) & 12'hFFF)) & 12'hFFF;
  endfunction

  function automatic int findWay(int s, int k);
    int r = -1;
    for (int w = 3; w >= 0; w--) if (cv[s][w] && ck[s][w] == k) r = w;
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doAccess(int pc, int blk, bit miss);
    int i, t, h, os, ns, kn, sn, wn, ob, ko, so, wo, v, bc;
    bit seed, eV;
    int eB;
    i = blk & 15; t = blk >> 4; h = hsh(pc); os = hs[i];
    seed = miss || !hv[i];
    ns = seed ? h : ((((os << 1) | (os >> 11)) & 12'hFFF) ^ h);
    kn = (ns ^ blk) & 12'hFFF; sn = kn & 3; wn = findWay(sn, kn);
    eV = (wn >= 0) && (cc[sn][wn] >= 2);
    eB = eV ? cp[sn][wn] : 0;
    ob = ((ht[i] << 4) | i) & 16'hFFFF;
    ko = (os ^ ob) & 12'hFFF; so = ko & 3; wo = findWay(so, ko);
    accPc = pc[15:0]; accBlk = blk[15:0]; accMiss = miss; accValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    accValid = 1'b0;
    lastV = pfValid; lastB = pfBlk;
    // R2 R3 R4 R5 R6 R7 R8 R9
    check(pfValid === eV, "R8 pfValid (R2 R3 R4 R5 R6 R7 R9)", int'(pfValid), int'(eV));
    if (eV) check(pfBlk === eB[15:0], "R8 pfBlk", int'(pfBlk), eB);
    if (hv[i] && miss) begin
      if (wo >= 0) begin
        if (cp[so][wo] == blk) cc[so][wo] = (cc[so][wo] == 3) ? 3 : cc[so][wo] + 1;
        else begin cp[so][wo] = blk; cc[so][wo] = 1; end
      end else begin
        v = 0; bc = cc[so][0];
        for (int w = 1; w < 4; w++) if (cc[so][w] < bc) begin bc = cc[so][w]; v = w; end
        cv[so][v] = 1; ck[so][v] = ko; cp[so][v] = blk; cc[so][v] = 1;
      end
    end else if (hv[i] && !miss && wo >= 0) begin
      cc[so][wo] = (cc[so][wo] == 0) ? 0 : cc[so][wo] - 1;
    end
    hv[i] = 1; ht[i] = t; hs[i] = ns;
  endtask

  task automatic auto(int pc, int blk);
    int i = blk & 15;
    doAccess(pc, blk, !(hv[i] && ht[i] == (blk >> 4)));
  endtask

  task automatic round(bit extra);
    auto(16'h1234, 16'h0011);
    auto(16'h2468, 16'h0011);
    auto(16'h3579, 16'h0011);
    if (extra) auto(16'h5A5A, 16'h0011);
    auto(16'h4C0F, 16'h0021);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin hv[i] = 0; ht[i] = 0; hs[i] = 0; end
    for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) begin
      cv[s][w] = 0; ck[s][w] = 0; cp[s][w] = 0; cc[s][w] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(pfValid === 1'b0, "R1 reset pfValid", int'(pfValid), 0);

    // directed learning: A(0x0011) is replaced by B(0x0021) after P1 P2 P3
    round(0);
    round(0);
    auto(16'h1234, 16'h0011);
    auto(16'h2468, 16'h0011);
    auto(16'h3579, 16'h0011);
    // R6 R8: second training made confidence 2, so the third pass predicts B
    check(lastV === 1'b1 && lastB === 16'h0021, "R6 learned prefetch", int'(lastB), 16'h0021);
    auto(16'h4C0F, 16'h0021);
    round(1);
    round(1);
    auto(16'h1234, 16'h0011);
    auto(16'h2468, 16'h0011);
    auto(16'h3579, 16'h0011);
    // R7: two surviving hits lowered the confidence from 3 to 1
    check(lastV === 1'b0, "R7 decremented no prefetch", int'(lastV), 0);
    auto(16'h4C0F, 16'h0021);

    // R10: idle cycles with moving inputs
    for (int k = 0; k < 6; k++) begin
      accPc = 16'(k * 977); accBlk = 16'(k * 31); accMiss = k[0];
      @(negedge clk);
      check(pfValid === 1'b0, "R10 idle pfValid", int'(pfValid), 0);
    end
    round(0);
    round(0);

    // structured sweep: repeating per-line patterns, set overflow for R9
    for (int rep = 0; rep < 8; rep++)
      for (int ln = 0; ln < 16; ln++) begin
        auto(16'h0100 + ln * 16'h0111, ((rep % 3) << 4) | ln);
        auto(16'h8000 + ln * 16'h0203, ((rep % 3) << 4) | ln);
        if (ln[0]) auto(16'h4400 + ln, ((rep % 3) << 4) | ln);
      end

    // pseudo-random stream
    begin
      logic [15:0] r = 16'hACE1;
      int pool [4] = '{16'h1234, 16'h0ABC, 16'h4F10, 16'h7777};
      for (int n = 0; n < 2500; n++) begin
        r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
        auto(pool[r[6:5]], (int'(r[4:3]) << 4) | int'(r[2:0]));
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule